// File: doc/BRIEF.md
# Processor trace status sequencer

This block turns event strobes from a simple processor core into a real-time trace stream. Every cycle it drives a 4-bit status code; alongside, it can drive a 32-bit data word together with a valid flag whenever the status code is a data marker. The core reports instruction starts, exception entry (normal or reset), stack-frame writes, exception vector fetches, taken branches and jumps with their targets, and operand reads and writes with their data.

Events enter a small in-order queue and are replayed one status step per cycle. While an exception is being processed, the background status is the exception code rather than idle. Operand data is filtered by a two-bit capture setting, by the reset exception (whose initial pointer fetches are never shown), and by line-burst detection during multi-register moves. Jump targets are shown only for the addressing modes whose target is not fixed at compile time.

Top module: `trace_status_seq`

## Requirements
- R1: With no queued event and no exception in progress, `st` is 0x0 and `dv` is low on every cycle.
- R2: A synchronous active-high `rst` sets `st` to 0x0, `dv` and `busy` low, ends any exception and discards all queued events, so that nothing is emitted afterwards.
- R3: From the cycle an exception entry is emitted until its handler branch is dequeued, every cycle without a marker, an instruction code or a branch code shows status 0xC with `dv` low.
- R4: A normal exception (kind 1, `ev_rst` low) followed by two stack writes (kind 2), a vector read (kind 3) and a branch (kind 4) emits 0xC, then 0xB with each stack word, then 0xB with the vector word, then 0x5 and the target marker; stack writes count as destination data and the vector read as source data for R8.
- R5: A reset exception (kind 1, `ev_rst` high) emits 0xC, then 0x5 and the handler target marker; every data strobe (kinds 2, 3, 6, 7) dequeued while a reset exception is in progress is not emitted, and data strobes after the handler branch are emitted normally.
- R6: A taken branch (kind 4) emits 0x5 with `dv` low, and on the next cycle a target marker with `dv` high and the target on `data`; the marker is 0x9 when target bits 31:8 are zero, 0xA when only bits 31:16 are zero, else 0xB.
- R7: A jump (kind 5) emits 0x5; its target marker follows only when `ev_mode` is 0, 1, 2 or 3 (register indirect, indirect with 16-bit displacement, indexed with 8-bit displacement, PC-relative indexed); modes 4 to 7 emit no target.
- R8: `cap_mode` 0 emits no operand data, 1 emits reads only (kinds 3 and 6), 2 or 3 emits reads and writes (kinds 2, 3, 6, 7); each emitted datum shows status 0xB with `dv` high and the word on `data`, and a suppressed datum shows only the background status.
- R9: An operand (kind 6 or 7) with `ev_multi` high is never emitted when `ev_addr_lo` is 0 and `ev_left` is 4 or more, nor for the following multi-register operands of that 16-byte line (non-zero `ev_addr_lo`); a line reached with fewer than 4 registers left is emitted normally.
- R10: An instruction start (kind 0) emits 0x1 with `dv` low; a multiply-accumulate with load is kind 0 then kind 6 (0x1, 0xB source), and the subtract-with-load form adds kind 7 (a further 0xB destination).
- R11: Events are accepted when `ev_valid` is high and `busy` is low; `busy` is high exactly when 4 events are queued; accepted events are emitted in arrival order and none is lost.
- R12: `dv` is high only together with status 0x9, 0xA or 0xB, and `data` is zero when `dv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_mode | input | 2 | Operand capture setting: 0 none, 1 reads, 2/3 reads and writes |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind: 0 instr, 1 exception, 2 stack write, 3 vector read, 4 branch, 5 jump, 6 operand read, 7 operand write |
| ev_word | input | 32 | Operand data or branch/jump target |
| ev_rst | input | 1 | Exception entry is a reset exception |
| ev_mode | input | 3 | Jump addressing mode code |
| ev_multi | input | 1 | Operand belongs to a multi-register move |
| ev_addr_lo | input | 4 | Low four bits of the operand address |
| ev_left | input | 5 | Registers left to transfer, this one included |
| busy | output | 1 | Event queue full; strobes are not accepted |
| st | output | 4 | Trace status code |
| dv | output | 1 | Data word valid |
| data | output | 32 | Trace data word |

## Verification
The bench builds the block with its default parameters: a queue depth of 4, 32-bit words and a 5-bit register count. With depth 4, eight back-to-back branches (two output cycles each) are enough to fill the queue and hold `busy`, so loss-free back-pressure and ordering can be checked. The 32-bit word lets targets land in each of the three marker widths, and the 5-bit count reaches both sides of the four-register line-burst threshold.

// File: rtl/trace_status_seq.sv
module trace_status_seq #(
  parameter int DEPTH = 4,
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cap_mode,
  input  logic          ev_valid,
  input  logic [2:0]    ev_kind,
  input  logic [DW-1:0] ev_word,
  input  logic          ev_rst,
  input  logic [2:0]    ev_mode,
  input  logic          ev_multi,
  input  logic [3:0]    ev_addr_lo,
  input  logic [LW-1:0] ev_left,
  output logic          busy,
  output logic [3:0]    st,
  output logic          dv,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  localparam logic [2:0] K_INSTR = 3'd0, K_EXC = 3'd1, K_STACK = 3'd2, K_VECT = 3'd3,
                         K_BRANCH = 3'd4, K_JUMP = 3'd5, K_RD = 3'd6, K_WR = 3'd7;

  typedef struct packed {
    logic [2:0]    kind;
    logic [DW-1:0] word;
    logic          rs;
    logic [2:0]    mode;
    logic          multi;
    logic [3:0]    lo;
    logic [LW-1:0] left;
  } ent_t;

  ent_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic phase_q, exc_q, rst_q, burst_q;

  ent_t hd;
  logic empty, push, pop, nphase;
  logic [3:0] bg, nst, tmark;
  logic ndv;
  logic [DW-1:0] ndata;
  logic aligned, burst_hit, is_op, is_rd, is_wr, cap_ok, show_data, show_tgt;

  assign hd    = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign busy  = (cnt == FULL_CNT);
  assign push  = ev_valid && !busy;
  assign bg    = exc_q ? 4'hC : 4'h0;

  assign aligned   = (hd.lo == 4'd0);
  assign burst_hit = hd.multi && ((aligned && hd.left >= LW'(4)) || (burst_q && !aligned));
  assign is_op     = (hd.kind == K_RD) || (hd.kind == K_WR);
  assign is_rd     = (hd.kind == K_RD) || (hd.kind == K_VECT);
  assign is_wr     = (hd.kind == K_WR) || (hd.kind == K_STACK);
  assign cap_ok    = is_rd ? (cap_mode != 2'd0) : (is_wr && cap_mode[1]);
  assign show_data = cap_ok && !(exc_q && rst_q) && !(is_op && burst_hit);
  assign show_tgt  = (hd.kind == K_BRANCH) || (hd.kind == K_JUMP && hd.mode < 3'd4);
  assign tmark     = (hd.word[DW-1:16] != '0) ? 4'hB :
                     (hd.word[15:8] != 8'd0)  ? 4'hA : 4'h9;

  always_comb begin
    nst    = bg;
    ndv    = 1'b0;
    ndata  = '0;
    pop    = 1'b0;
    nphase = phase_q;
    if (!empty) begin
      if (phase_q) begin
        nst    = tmark;
        ndv    = 1'b1;
        ndata  = hd.word;
        pop    = 1'b1;
        nphase = 1'b0;
      end else begin
        case (hd.kind)
          K_INSTR: begin nst = 4'h1; pop = 1'b1; end
          K_EXC:   begin nst = 4'hC; pop = 1'b1; end
          K_BRANCH, K_JUMP: begin
            nst = 4'h5;
            if (show_tgt) nphase = 1'b1;
            else pop = 1'b1;
          end
          default: begin
            pop = 1'b1;
            if (show_data) begin
              nst   = 4'hB;
              ndv   = 1'b1;
              ndata = hd.word;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr] <= '{kind: ev_kind, word: ev_word, rs: ev_rst, mode: ev_mode,
                       multi: ev_multi, lo: ev_addr_lo, left: ev_left};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      phase_q <= 1'b0;
      exc_q   <= 1'b0;
      rst_q   <= 1'b0;
      burst_q <= 1'b0;
      st      <= 4'h0;
      dv      <= 1'b0;
      data    <= '0;
    end else begin
      st      <= nst;
      dv      <= ndv;
      data    <= ndata;
      phase_q <= nphase;
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (pop) begin
        case (hd.kind)
          K_EXC:            begin exc_q <= 1'b1; rst_q <= hd.rs; end
          K_BRANCH, K_JUMP: begin exc_q <= 1'b0; rst_q <= 1'b0; end
          K_INSTR:          burst_q <= 1'b0;
          K_RD, K_WR:       burst_q <= burst_hit;
          default:          ;
        endcase
      end
    end
  end
endmodule

module trace_status_seq_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [3:0]                 st,
  input logic                       dv,
  input logic                       busy,
  input logic                       ev_valid,
  input logic [$clog2(DEPTH+1)-1:0] cnt,
  input logic                       phase_q,
  input logic                       exc_q
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !exc_q) |=> (st == 4'h0 && !dv));

  assert_exc_background_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && exc_q) |=> (st == 4'hC && !dv));

  assert_branch_code_R6: assert property (@(posedge clk) disable iff (rst)
    phase_q |-> (st == 4'h5 && !dv));

  assert_target_marker_R6: assert property (@(posedge clk) disable iff (rst)
    phase_q |=> (dv && st >= 4'h9 && st <= 4'hB));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && ev_valid) |=> (cnt <= $past(cnt)));

  assert_dv_marker_R12: assert property (@(posedge clk) disable iff (rst)
    dv |-> (st == 4'h9 || st == 4'hA || st == 4'hB));
endmodule

bind trace_status_seq trace_status_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .st(st), .dv(dv), .busy(busy), .ev_valid(ev_valid),
  .cnt(cnt), .phase_q(phase_q), .exc_q(exc_q)
);

// File: tb/test_trace_status_seq.sv
module test_trace_status_seq;
  localparam logic [2:0] K_INSTR = 3'd0, K_EXC = 3'd1, K_STACK = 3'd2, K_VECT = 3'd3,
                         K_BRANCH = 3'd4, K_JUMP = 3'd5, K_RD = 3'd6, K_WR = 3'd7;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cap_mode = 2'd2;
  logic ev_valid = 1'b0, ev_rst = 1'b0, ev_multi = 1'b0;
  logic [2:0] ev_kind = '0, ev_mode = '0;
  logic [31:0] ev_word = '0;
  logic [3:0] ev_addr_lo = '0;
  logic [4:0] ev_left = '0;
  logic busy, dv;
  logic [3:0] st;
  logic [31:0] data;

  int checks = 0, failures = 0;
  bit logging = 0, busy_seen = 0;
  int ln = 0, en = 0;
  logic [3:0] lst [32];
  logic lv [32];
  logic [31:0] ld [32];
  logic [3:0] xst [32];
  logic xv [32];
  logic [31:0] xd [32];

  trace_status_seq i_trace_status_seq (
    .clk(clk), .rst(rst), .cap_mode(cap_mode), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_word(ev_word), .ev_rst(ev_rst), .ev_mode(ev_mode), .ev_multi(ev_multi),
    .ev_addr_lo(ev_addr_lo), .ev_left(ev_left), .busy(busy), .st(st), .dv(dv), .data(data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (logging) begin
    if (busy) busy_seen = 1;
    if (st != 4'h0 && !(st == 4'hC && !dv && ln > 0 && lst[ln-1] == 4'hC && !lv[ln-1])) begin
      if (ln < 32) begin lst[ln] = st; lv[ln] = dv; ld[ln] = data; end
      ln++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [31:0] w, input logic r = 0,
                      input logic [2:0] m = 0, input logic mu = 0, input logic [3:0] lo = 0,
                      input logic [4:0] left = 0);
    while (busy) @(negedge clk);
    ev_valid = 1; ev_kind = k; ev_word = w; ev_rst = r; ev_mode = m;
    ev_multi = mu; ev_addr_lo = lo; ev_left = left;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic begin_log();
    @(negedge clk);
    ln = 0; en = 0; busy_seen = 0; logging = 1;
  endtask

  task automatic add(input logic [3:0] s, input logic v, input logic [31:0] d);
    xst[en] = s; xv[en] = v; xd[en] = d; en++;
  endtask

  task automatic end_log(input string req);
    repeat (20) @(negedge clk);
    logging = 0;
    chk(ln == en, {req, " entry count"}, 64'(ln), 64'(en));
    for (int i = 0; i < en && i < ln; i++)
      chk(lst[i] == xst[i] && lv[i] == xv[i] && ld[i] == xd[i], req,
          {27'd0, lst[i], lv[i], ld[i]}, {27'd0, xst[i], xv[i], xd[i]});
  endtask

  task automatic t_reset();
    chk(st == 4'h0 && !dv && !busy && data == 0, "R2 reset state", {st, dv, busy}, 0);
    repeat (3) @(negedge clk);
    chk(st == 4'h0 && !dv, "R1 idle", {st, dv}, 0);
    for (int i = 0; i < 5; i++) send(K_BRANCH, 32'h100 + i);
    rst = 1;
    @(negedge clk);
    chk(st == 4'h0 && !dv && !busy, "R2 mid-stream reset", {st, dv, busy}, 0);
    rst = 0;
    begin_log();
    end_log("R2 queue emptied");
  endtask

  task automatic t_branch();
    cap_mode = 2'd2;
    begin_log();
    send(K_BRANCH, 32'h40);
    send(K_BRANCH, 32'h1234);
    send(K_BRANCH, 32'h00123456);
    add(4'h5, 0, 0); add(4'h9, 1, 32'h40);
    add(4'h5, 0, 0); add(4'hA, 1, 32'h1234);
    add(4'h5, 0, 0); add(4'hB, 1, 32'h00123456);
    end_log("R6 R12 branch markers");
  endtask

  task automatic t_jump();
    begin_log();
    send(K_JUMP, 32'h10, 0, 3'd0);
    send(K_JUMP, 32'h20, 0, 3'd5);
    send(K_JUMP, 32'h30, 0, 3'd3);
    send(K_JUMP, 32'h40, 0, 3'd6);
    send(K_JUMP, 32'h50, 0, 3'd1);
    send(K_JUMP, 32'h60, 0, 3'd4);
    add(4'h5, 0, 0); add(4'h9, 1, 32'h10);
    add(4'h5, 0, 0);
    add(4'h5, 0, 0); add(4'h9, 1, 32'h30);
    add(4'h5, 0, 0);
    add(4'h5, 0, 0); add(4'h9, 1, 32'h50);
    add(4'h5, 0, 0);
    end_log("R7 jump target modes");
  endtask

  task automatic t_mac();
    cap_mode = 2'd2;
    begin_log();
    send(K_INSTR, 0);
    send(K_INSTR, 0); send(K_RD, 32'hA1);
    send(K_INSTR, 0); send(K_RD, 32'hB1); send(K_WR, 32'hB2);
    add(4'h1, 0, 0);
    add(4'h1, 0, 0); add(4'hB, 1, 32'hA1);
    add(4'h1, 0, 0); add(4'hB, 1, 32'hB1); add(4'hB, 1, 32'hB2);
    end_log("R10 multiply-accumulate forms");
  endtask

  task automatic t_capture();
    cap_mode = 2'd0;
    begin_log();
    send(K_INSTR, 0); send(K_RD, 32'hC1); send(K_WR, 32'hC2);
    add(4'h1, 0, 0);
    end_log("R8 capture none");
    cap_mode = 2'd1;
    begin_log();
    send(K_INSTR, 0); send(K_RD, 32'hD1); send(K_WR, 32'hD2);
    add(4'h1, 0, 0); add(4'hB, 1, 32'hD1);
    end_log("R8 capture reads");
    cap_mode = 2'd3;
    begin_log();
    send(K_INSTR, 0); send(K_RD, 32'hE1); send(K_WR, 32'hE2);
    add(4'h1, 0, 0); add(4'hB, 1, 32'hE1); add(4'hB, 1, 32'hE2);
    end_log("R8 capture both");
  endtask

  task automatic t_exception();
    cap_mode = 2'd2;
    begin_log();
    send(K_EXC, 0);
    repeat (4) @(negedge clk);
    chk(st == 4'hC && !dv, "R3 exception background", {st, dv}, 64'hC0);
    send(K_STACK, 32'h5A1); send(K_STACK, 32'h5A2); send(K_VECT, 32'h7C);
    send(K_BRANCH, 32'h00ABCDEF);
    add(4'hC, 0, 0); add(4'hB, 1, 32'h5A1); add(4'hB, 1, 32'h5A2); add(4'hB, 1, 32'h7C);
    add(4'h5, 0, 0); add(4'hB, 1, 32'h00ABCDEF);
    end_log("R4 normal exception");
    chk(st == 4'h0 && !dv, "R3 exception ended", {st, dv}, 0);
    cap_mode = 2'd0;
    begin_log();
    send(K_EXC, 0); send(K_STACK, 32'h1); send(K_STACK, 32'h2); send(K_VECT, 32'h3);
    send(K_BRANCH, 32'h88);
    add(4'hC, 0, 0); add(4'h5, 0, 0); add(4'h9, 1, 32'h88);
    end_log("R3 R8 exception without capture");
  endtask

  task automatic t_reset_exc();
    cap_mode = 2'd2;
    begin_log();
    send(K_EXC, 0, 1);
    send(K_RD, 32'h2000, 0, 0, 0, 4'h0);
    send(K_RD, 32'h400, 0, 0, 0, 4'h4);
    send(K_BRANCH, 32'h400);
    send(K_RD, 32'h99);
    add(4'hC, 0, 0); add(4'h5, 0, 0); add(4'hA, 1, 32'h400); add(4'hB, 1, 32'h99);
    end_log("R5 reset exception");
  endtask

  task automatic t_burst();
    cap_mode = 2'd2;
    begin_log();
    send(K_INSTR, 0);
    send(K_WR, 32'hF8, 0, 0, 1, 4'h8, 5'd6);
    send(K_WR, 32'hFC, 0, 0, 1, 4'hC, 5'd5);
    send(K_WR, 32'hF0, 0, 0, 1, 4'h0, 5'd4);
    send(K_WR, 32'hF4, 0, 0, 1, 4'h4, 5'd3);
    send(K_WR, 32'hF9, 0, 0, 1, 4'h8, 5'd2);
    send(K_WR, 32'hFD, 0, 0, 1, 4'hC, 5'd1);
    add(4'h1, 0, 0); add(4'hB, 1, 32'hF8); add(4'hB, 1, 32'hFC);
    end_log("R9 line burst suppressed");
    begin_log();
    send(K_INSTR, 0);
    send(K_RD, 32'hE0, 0, 0, 1, 4'h0, 5'd3);
    send(K_RD, 32'hE4, 0, 0, 1, 4'h4, 5'd2);
    add(4'h1, 0, 0); add(4'hB, 1, 32'hE0); add(4'hB, 1, 32'hE4);
    end_log("R9 short line shown");
  endtask

  task automatic t_fifo();
    begin_log();
    for (int i = 0; i < 8; i++) send(K_BRANCH, 32'h10 + i);
    for (int i = 0; i < 8; i++) begin add(4'h5, 0, 0); add(4'h9, 1, 32'h10 + i); end
    chk(busy_seen, "R11 busy when full", 64'(busy_seen), 1);
    end_log("R11 no event lost");
    chk(!busy, "R11 busy clears", 64'(busy), 0);
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_branch();
    t_jump();
    t_mac();
    t_capture();
    t_exception();
    t_reset_exc();
    t_burst();
    t_fifo();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule